// File: doc/BRIEF.md
# Time-Triggered Priority-Division Bus Arbiter

This block shares one bus among several cores on a fixed, repeating time schedule. A free-running counter walks through a period made of one slot per core, each slot a fixed number of cycles long. Slot `s` belongs to core `s`. A transfer may start only at a slot position from which the longest possible transfer still finishes before the slot ends. Once a transfer has started, it keeps the bus until the target reports that it is done.

The block has two modes, selected by the static `pd_mode` input. With `pd_mode` low, the arbiter runs as a strict time-division scheme: only the owner of the current slot is ever started. With `pd_mode` high, every core holds a rank in every slot. The owner ranks highest in its own slot, so the owner keeps its guaranteed start. Any other requester can still use slot time that the owner leaves idle.

The control is a three-state machine:
- `XS_IDLE`: no transfer is running.
- `XS_OWNER`: the current transfer belongs to the slot owner.
- `XS_LOAN`: the current transfer belongs to a core that borrowed another core's slot.

Its transitions are:
- IDLE→OWNER and IDLE→LOAN happen at a start opportunity with an eligible winner.
- OWNER/LOAN→IDLE happens when the target signals done and no winner exists.
- OWNER/LOAN→OWNER/LOAN (back-to-back) happens when the target signals done and a new winner starts at the same edge.
- OWNER/LOAN→self happens while no done is seen.

Top module: `tdpd_bus_arbiter`

## Requirements
- R1: After reset is released, the slot position advances by one each clock and wraps at SLOT_LEN. `cur_slot` therefore reads 0 until the first wrap, then steps 0,1,…,N_CORES-1,0 every SLOT_LEN cycles.
- R2: While `rst_n` is low, `grant` is all-zero and `cur_slot` is 0, whatever the requests.
- R3: At most one bit of `grant` is ever set.
- R4: A transfer starts only in a cycle whose slot position p satisfies p + MAX_ACC ≤ SLOT_LEN. With requests present at any other position, no new grant appears.
- R5: With `pd_mode` = 0, only core `s` can be started while `cur_slot` = s. A request seen in the cycle before a start position is granted in that cycle, provided the bus is free.
- R6: With `pd_mode` = 1, the rank of core c in slot s is N_CORES-1-((c-s) mod N_CORES). At a start position the eligible requester with the highest rank is granted, and equal ranks go to the lower index. A non-owner is therefore granted when the owner is not requesting.
- R7: A grant stays unchanged until a cycle in which it is set and `tgt_done` is high. It may change only at the following edge.
- R8: `tgt_done` while no grant is set has no effect. Without requests the grant stays all-zero.
- R9: A core that keeps requesting waits no more than one full period (N_CORES·SLOT_LEN cycles) between grants.
- R10: When `tgt_done` arrives in the cycle just before a start position, the next winner is granted at that start position with no idle cycle in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_mode | input | 1 | 0 = strict time division, 1 = priority division |
| req | input | N_CORES | One request line per core |
| tgt_done | input | 1 | Target ends the running transfer in this cycle |
| grant | output | N_CORES | One-hot or zero bus grant |
| cur_slot | output | $clog2(N_CORES) | Index of the current slot |

## Verification
The hardest situation to reach from the ports is a transfer ending exactly at the edge before a start position while another core waits. That case exercises the back-to-back handover and the owner's guaranteed start at once. The bench uses a reduced configuration with three cores, four-cycle slots and two-cycle maximum transfers. It sweeps every request mask in both modes for two full periods each, while the length of each transfer cycles through 1 and 2. This makes the end of a transfer land on every slot position, including the one just before each start position. A final pass changes the request mask almost every cycle to cover requests that drop mid-transfer.

// File: rtl/tdpd_pkg.sv
package tdpd_pkg;

    typedef enum logic [1:0] {
        XS_IDLE  = 2'd0,
        XS_OWNER = 2'd1,
        XS_LOAN  = 2'd2
    } xfer_state_e;

    // Rank of a core within a slot: the slot owner ranks highest,
    // followed by the cores after it in circular order.
    function automatic int unsigned core_rank(input int unsigned slot,
                                              input int unsigned core,
                                              input int unsigned n_cores);
        return n_cores - 1 - ((core + n_cores - slot) % n_cores);
    endfunction

endpackage

// File: rtl/tdpd_slot_timer.sv
module tdpd_slot_timer #(
    parameter int unsigned N_CORES  = 4,
    parameter int unsigned SLOT_LEN = 3,
    parameter int unsigned SW       = 2,
    parameter int unsigned PW       = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    output logic [SW-1:0] slot_q,
    output logic [PW-1:0] pos_q,
    output logic [SW-1:0] slot_nx,
    output logic [PW-1:0] pos_nx
);

    localparam logic [PW-1:0] POS_LAST  = PW'(SLOT_LEN - 1);
    localparam logic [SW-1:0] SLOT_LAST = SW'(N_CORES - 1);

    always_comb begin
        if (pos_q == POS_LAST) begin
            pos_nx  = '0;
            slot_nx = (slot_q == SLOT_LAST) ? '0 : slot_q + 1'b1;
        end else begin
            pos_nx  = pos_q + 1'b1;
            slot_nx = slot_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pos_q  <= '0;
            slot_q <= '0;
        end else begin
            pos_q  <= pos_nx;
            slot_q <= slot_nx;
        end
    end

endmodule

// File: rtl/tdpd_eligible.sv
module tdpd_eligible #(
    parameter int unsigned N_CORES  = 4,
    parameter int unsigned SLOT_LEN = 3,
    parameter int unsigned MAX_ACC  = 3,
    parameter int unsigned SW       = 2,
    parameter int unsigned PW       = 2
) (
    input  logic [N_CORES-1:0] req,
    input  logic               pd_mode,
    input  logic [SW-1:0]      slot_nx,
    input  logic [PW-1:0]      pos_nx,
    output logic [N_CORES-1:0] elig
);

    // Last slot position from which a longest transfer still fits.
    localparam int unsigned WIN_LAST = SLOT_LEN - MAX_ACC;

    logic in_win;
    assign in_win = (32'(pos_nx) <= WIN_LAST);

    for (genvar c = 0; c < N_CORES; c++) begin : g_core
        logic owner_here;
        assign owner_here = (slot_nx == SW'(c));
        assign elig[c]    = req[c] & in_win & (pd_mode | owner_here);
    end

endmodule

// File: rtl/tdpd_rank_pick.sv
module tdpd_rank_pick
    import tdpd_pkg::*;
#(
    parameter int unsigned N_CORES = 4,
    parameter int unsigned SW      = 2
) (
    input  logic [N_CORES-1:0] elig,
    input  logic [SW-1:0]      slot_nx,
    output logic [N_CORES-1:0] pick,
    output logic               pick_any,
    output logic               pick_owner
);

    int unsigned best_rank;
    int unsigned best_idx;
    int unsigned this_rank;
    logic        found;

    always_comb begin
        best_rank = 0;
        best_idx  = 0;
        this_rank = 0;
        found     = 1'b0;
        for (int c = 0; c < int'(N_CORES); c++) begin
            if (elig[c]) begin
                this_rank = core_rank(32'(slot_nx), 32'(c), N_CORES);
                // strict compare keeps the lower index on equal rank
                if (!found || this_rank > best_rank) begin
                    found     = 1'b1;
                    best_rank = this_rank;
                    best_idx  = 32'(c);
                end
            end
        end
        for (int c = 0; c < int'(N_CORES); c++) begin
            pick[c] = found && (best_idx == 32'(c));
        end
        pick_any   = found;
        pick_owner = found && (best_idx == 32'(slot_nx));
    end

endmodule

// File: rtl/tdpd_bus_arbiter.sv
module tdpd_bus_arbiter
    import tdpd_pkg::*;
#(
    parameter int unsigned N_CORES  = 4,
    parameter int unsigned SLOT_LEN = 3,
    parameter int unsigned MAX_ACC  = 3,
    localparam int unsigned SW = (N_CORES > 1) ? $clog2(N_CORES) : 1,
    localparam int unsigned PW = (SLOT_LEN > 1) ? $clog2(SLOT_LEN) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               pd_mode,
    input  logic [N_CORES-1:0] req,
    input  logic               tgt_done,
    output logic [N_CORES-1:0] grant,
    output logic [SW-1:0]      cur_slot
);

    logic [SW-1:0]      slot_nx;
    logic [PW-1:0]      slot_pos;
    logic [PW-1:0]      pos_nx;
    logic [N_CORES-1:0] elig;
    logic [N_CORES-1:0] pick;
    logic               pick_any;
    logic               pick_owner;

    xfer_state_e        state_q, state_d;
    logic [N_CORES-1:0] grant_q, grant_d;
    logic               launch;

    tdpd_slot_timer #(
        .N_CORES (N_CORES),
        .SLOT_LEN(SLOT_LEN),
        .SW      (SW),
        .PW      (PW)
    ) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .slot_q (cur_slot),
        .pos_q  (slot_pos),
        .slot_nx(slot_nx),
        .pos_nx (pos_nx)
    );

    tdpd_eligible #(
        .N_CORES (N_CORES),
        .SLOT_LEN(SLOT_LEN),
        .MAX_ACC (MAX_ACC),
        .SW      (SW),
        .PW      (PW)
    ) u_elig (
        .req    (req),
        .pd_mode(pd_mode),
        .slot_nx(slot_nx),
        .pos_nx (pos_nx),
        .elig   (elig)
    );

    tdpd_rank_pick #(
        .N_CORES(N_CORES),
        .SW     (SW)
    ) u_pick (
        .elig      (elig),
        .slot_nx   (slot_nx),
        .pick      (pick),
        .pick_any  (pick_any),
        .pick_owner(pick_owner)
    );

    // A new transfer may be decided when the bus is free or frees at this edge.
    assign launch = (state_q == XS_IDLE) || tgt_done;

    always_comb begin
        state_d = state_q;
        grant_d = grant_q;
        unique case (state_q)
            XS_IDLE: begin
                if (pick_any) begin
                    state_d = pick_owner ? XS_OWNER : XS_LOAN;
                end
            end
            XS_OWNER, XS_LOAN: begin
                if (tgt_done) begin
                    if (pick_any) begin
                        state_d = pick_owner ? XS_OWNER : XS_LOAN;
                    end else begin
                        state_d = XS_IDLE;
                    end
                end
            end
            default: state_d = XS_IDLE;
        endcase
        if (launch) begin
            grant_d = pick;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= XS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            grant_q <= '0;
        end else begin
            grant_q <= grant_d;
        end
    end

    assign grant = grant_q;

endmodule

// File: rtl/tdpd_checker.sv
module tdpd_checker #(
    parameter int unsigned N_CORES  = 4,
    parameter int unsigned SLOT_LEN = 3,
    parameter int unsigned MAX_ACC  = 3,
    parameter int unsigned SW       = 2,
    parameter int unsigned PW       = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               pd_mode,
    input logic [N_CORES-1:0] req,
    input logic               tgt_done,
    input logic [N_CORES-1:0] grant,
    input logic [SW-1:0]      cur_slot,
    input logic [PW-1:0]      slot_pos
);

    AST_GRANT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R3

    AST_START_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && !$stable(grant)) |-> (32'(slot_pos) + MAX_ACC <= SLOT_LEN)); // R4

    AST_TDMA_OWNER_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (!pd_mode && grant != '0 && !$stable(grant)) |-> grant[cur_slot]); // R5

    AST_HOLD_UNTIL_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (grant != '0 && !tgt_done) |=> $stable(grant)); // R7

    AST_NO_SPURIOUS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (grant == '0 && req == '0) |=> (grant == '0)); // R8

    AST_POS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(slot_pos) == SLOT_LEN - 1) |=> (slot_pos == '0)); // R1

    AST_SLOT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(slot_pos) != SLOT_LEN - 1) |=> $stable(cur_slot)); // R1

endmodule

bind tdpd_bus_arbiter tdpd_checker #(
    .N_CORES (N_CORES),
    .SLOT_LEN(SLOT_LEN),
    .MAX_ACC (MAX_ACC),
    .SW      (SW),
    .PW      (PW)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .pd_mode (pd_mode),
    .req     (req),
    .tgt_done(tgt_done),
    .grant   (grant),
    .cur_slot(cur_slot),
    .slot_pos(slot_pos)
);

// File: tb/tdpd_bus_arbiter_tb.sv
module tdpd_bus_arbiter_tb;

    localparam int N  = 3;
    localparam int L  = 4;
    localparam int M  = 2;
    localparam int P  = N * L;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pd_mode = 1'b0;
    logic [N-1:0]  req = '0;
    logic          tgt_done = 1'b0;
    logic [N-1:0]  grant;
    logic [SW-1:0] cur_slot;

    int n_checks = 0;
    int n_fail   = 0;

    int           m_off   = 0;
    logic [N-1:0] exp_g   = '0;
    logic [N-1:0] prev_act = '0;
    int           busy    = 0;
    int           cur_len = 1;
    int           len_sel = 0;
    int           waitc [N];

    always #10 clk = ~clk; // 50 MHz

    tdpd_bus_arbiter #(
        .N_CORES (N),
        .SLOT_LEN(L),
        .MAX_ACC (M)
    ) u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .pd_mode (pd_mode),
        .req     (req),
        .tgt_done(tgt_done),
        .grant   (grant),
        .cur_slot(cur_slot)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Called at a negedge: drive one cycle, predict, then check at the next negedge.
    task automatic step(input logic [N-1:0] r, input bit extra_done);
        int off_n, pos_n, slot_n, best, best_rk, rk;
        logic [N-1:0] exp_n, prev;
        bit d, launch;
        string tag;
        d = extra_done || (exp_g != '0 && busy == cur_len - 1);
        req = r;
        tgt_done = d;
        off_n  = (m_off + 1) % P;
        pos_n  = off_n % L;
        slot_n = off_n / L;
        launch = (exp_g == '0) || d;
        exp_n  = launch ? '0 : exp_g;
        if (launch && (pos_n + M <= L)) begin
            best = -1;
            best_rk = 0;
            for (int c = 0; c < N; c++) begin
                if (r[c] && (pd_mode || c == slot_n)) begin
                    rk = N - 1 - ((c - slot_n + N) % N);
                    if (best < 0 || rk > best_rk) begin
                        best = c;
                        best_rk = rk;
                    end
                end
            end
            if (best >= 0) exp_n[best] = 1'b1;
        end
        @(posedge clk);
        @(negedge clk);
        prev  = exp_g;
        m_off = off_n;
        if (launch && exp_n != '0) begin
            busy = 0;
            len_sel++;
            cur_len = 1 + (len_sel % M);
        end else if (exp_n != '0) begin
            busy++;
        end
        exp_g = exp_n;

        chk(int'(cur_slot) == slot_n, "R1 slot index", int'(cur_slot), slot_n);
        chk($countones(grant) <= 1, "R3 exclusive grant", int'(grant), int'(exp_n));
        if (exp_n != '0 && launch && prev != '0) tag = "R10 back-to-back grant";
        else if (exp_n != '0 && launch) tag = pd_mode ? "R6 rank winner" : "R5 owner grant";
        else if (exp_n != '0) tag = "R7 held grant";
        else if (r != '0) tag = "R4 no start outside window";
        else tag = "R8 idle stays idle";
        chk(grant == exp_n, tag, int'(grant), int'(exp_n));
        if (grant != '0 && grant != prev_act)
            chk(pos_n + M <= L, "R4 start position", pos_n, L - M);
        for (int c = 0; c < N; c++) begin
            if (r[c] && !grant[c]) begin
                waitc[c]++;
                chk(waitc[c] <= P, "R9 owner wait bound", waitc[c], P);
            end else begin
                waitc[c] = 0;
            end
        end
        prev_act = grant;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        for (int c = 0; c < N; c++) waitc[c] = 0;
        // reset with requests active: R2
        req = '1;
        tgt_done = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(grant == '0, "R2 reset grant", int'(grant), 0);
        chk(cur_slot == '0, "R2 reset slot", int'(cur_slot), 0);
        req = '0;
        tgt_done = 1'b0;
        rst_n = 1'b1;
        m_off = 0;

        // R1 and R8: no requests, stray done pulses
        pd_mode = 1'b0;
        for (int i = 0; i < 2 * P; i++) step('0, (i % 2) == 1);

        // R5: strict time division over all request masks
        for (int mk = 1; mk < (1 << N); mk++) begin
            for (int i = 0; i < 2 * P; i++) step(N'(mk), 1'b0);
        end
        for (int i = 0; i < P; i++) step('0, 1'b0);

        // R6: priority division over all request masks
        pd_mode = 1'b1;
        for (int mk = 1; mk < (1 << N); mk++) begin
            for (int i = 0; i < 2 * P; i++) step(N'(mk), 1'b0);
        end

        // R6, R7, R10: fast-changing patterns in priority division
        for (int i = 0; i < 3 * P; i++) step(N'((i * 5 + i / 3) % (1 << N)), 1'b0);
        for (int i = 0; i < P; i++) step('0, 1'b0);

        report();
    end

endmodule